// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counting Timer

This block holds a bank of independent countdown timers behind one simple synchronous register port. Each channel divides the clock by a programmable amount, counts down from a start value that software programs, and flags the moment it runs out. A channel either stops after one run (one-shot) or reloads and keeps going (periodic). Software can read the live count of every channel at any time. This is how a free-running time base or a single delayed event is built.

All expiry flags are collected in one shared status word. Software clears a flag by writing a one to its bit. Each channel's interrupt line is its flag gated by that channel's interrupt enable. The register port has an address, a write strobe and write data. Read data is combinational from the address.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every control, start-value and count register reads zero, the status word reads zero and all interrupt lines are low.
- R2: With the channel enabled and prescale P in control bits 7:0, the count falls by one exactly once every P+1 clocks. The first step comes P+1 clocks after the count is loaded.
- R3: In one-shot mode, the count steps from 1 and then expires. At that point the count becomes 0 and the enable bit (control bit 30) clears itself. One-shot mode is any value of the mode field (control bits 28:27) other than 01, and the field reads back as written.
- R4: In periodic mode (mode field 01), expiry reloads the start value into the count and the enable bit stays set, so the channel keeps running.
- R5: A control write that takes the enable bit from 0 to 1 loads the start value into the count on that clock and restarts the prescaler phase.
- R6: A write to the start-value register of an enabled channel reloads the count with the written value on that clock and restarts the prescaler phase. On a disabled channel the write only stores the value.
- R7: Status bit i sets on the clock that channel i expires, whether or not its interrupt enable (control bit 29) is set.
- R8: The status word sits at word address 4*NUM_CH. Writing a 1 to a bit clears it, and a 0 bit leaves it unchanged. Bits at or above NUM_CH read zero.
- R9: Interrupt line i is high exactly when status bit i and channel i's interrupt enable are both set.
- R10: Channel i uses word addresses 4i (control), 4i+1 (start value) and 4i+2 (live count). Start value and count are CNT_W bits wide and read back zero-extended. The control word reads back as enable at bit 30, interrupt enable at bit 29, mode at bits 28:27 and prescale at bits 7:0, with all other bits zero.
- R11: A control write with the enable bit clear stops the channel. The count then holds its value and no further expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The bench builds the bank with NUM_CH=3, CNT_W=24 and ADDR_W=5. Three channels are enough to show that status bits belong to their own channel and that the status word sits directly above the last channel. The full 24-bit count width lets a start value with every bit set show the zero-extension and the width mask. Small start values and prescales keep each expiry within tens of clocks, so exact-cycle checks of the prescale spacing, one-shot stop, periodic reload and mid-run reload are cheap. A prescale of 255 checks the widest divider.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int DATA_W   = 32;
   localparam int PRE_W    = 8;
   localparam int BIT_EN   = 30;
   localparam int BIT_IE   = 29;
   localparam int MODE_HI  = 28;
   localparam int MODE_LO  = 27;
   localparam int OFF_CTL  = 0;
   localparam int OFF_INIT = 1;
   localparam int OFF_CNT  = 2;

   typedef enum logic [1:0] {
      MODE_ONESHOT  = 2'b00,
      MODE_PERIODIC = 2'b01
   } tmr_mode_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);
   logic [PRE_W-1:0] phase_q;

   assign tick = run && !restart && (phase_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        phase_q <= '0;
      else if (!run || restart || tick)  phase_q <= '0;
      else                               phase_q <= phase_q + 1'b1;
   end

   // R2: an idle divider always starts from phase zero
   a_r2_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> phase_q == '0);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              init_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctl_word,
   output logic [CNT_W-1:0]  init_val,
   output logic [CNT_W-1:0]  count,
   output logic              ie,
   output logic              expire
);
   logic [PRE_W-1:0] pre_q;
   logic [1:0]       mode_q;
   logic             ie_q, en_q;
   logic [CNT_W-1:0] init_q, cnt_q;
   logic             load, halt, tick, step, periodic;
   logic [CNT_W-1:0] load_val;
   logic             unused_wbits;

   assign unused_wbits = ^wdata;
   assign periodic = (mode_q == MODE_PERIODIC);
   assign load     = (ctl_we && !en_q && wdata[BIT_EN]) || (init_we && en_q);
   assign load_val = ctl_we ? init_q : wdata[CNT_W-1:0];
   assign halt     = ctl_we && !wdata[BIT_EN];
   assign step     = tick && !halt;
   assign expire   = step && (cnt_q <= CNT_W'(1));

   tmr_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(en_q), .restart(load),
      .div(pre_q), .tick(tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         mode_q <= MODE_ONESHOT;
         ie_q   <= 1'b0;
         en_q   <= 1'b0;
      end else if (ctl_we) begin
         pre_q  <= wdata[PRE_W-1:0];
         mode_q <= wdata[MODE_HI:MODE_LO];
         ie_q   <= wdata[BIT_IE];
         en_q   <= wdata[BIT_EN];
      end else if (expire && !periodic) begin
         en_q   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       init_q <= '0;
      else if (init_we) init_q <= wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load)   cnt_q <= load_val;
      else if (expire) cnt_q <= periodic ? init_q : '0;
      else if (step)   cnt_q <= cnt_q - 1'b1;
   end

   assign ctl_word = {1'b0, en_q, ie_q, mode_q, {(MODE_LO-PRE_W){1'b0}}, pre_q};
   assign init_val = init_q;
   assign count    = cnt_q;
   assign ie       = ie_q;

   // R2: the count moves only on a divider tick or a load
   a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !ctl_we && !init_we && !tick) |=> $stable(cnt_q));
   // R3: one-shot expiry parks at zero and disables
   a_r3_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !periodic && !ctl_we) |=> (cnt_q == '0) && !en_q);
   // R4: periodic expiry reloads and keeps running
   a_r4_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && periodic && !ctl_we) |=> (cnt_q == $past(init_q)) && en_q);
   // R5: enable rising edge loads the start value
   a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !en_q && wdata[BIT_EN]) |=> (cnt_q == $past(init_q)) && en_q);
   // R6: start-value write on a running channel reloads the count
   a_r6_live_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (init_we && en_q) |=> cnt_q == $past(wdata[CNT_W-1:0]));
   // R11: a control write with enable clear stops the channel
   a_r11_stop: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !en_q);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 5,
   parameter int CNT_W  = 24,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int IDX_W = ADDR_W - 2;
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(4 * NUM_CH);

   if (NUM_CH < 1 || NUM_CH > DATA_W)   $error("NUM_CH out of range");
   if (CNT_W < 2 || CNT_W > DATA_W)     $error("CNT_W out of range");
   if (ADDR_W < 3 || (4 * NUM_CH) >= (1 << ADDR_W)) $error("ADDR_W too small");

   logic [DATA_W-1:0] ctl_rd  [NUM_CH];
   logic [CNT_W-1:0]  init_rd [NUM_CH];
   logic [CNT_W-1:0]  cnt_rd  [NUM_CH];
   logic [NUM_CH-1:0] ie_v, expire_v, stat_q;
   logic              stat_we;

   assign stat_we = bus_we && (bus_addr == STAT_ADDR);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel;
      assign sel = (bus_addr[ADDR_W-1:2] == IDX_W'(i));

      tmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .ctl_we (bus_we && sel && (bus_addr[1:0] == 2'(OFF_CTL))),
         .init_we(bus_we && sel && (bus_addr[1:0] == 2'(OFF_INIT))),
         .wdata(bus_wdata),
         .ctl_word(ctl_rd[i]), .init_val(init_rd[i]), .count(cnt_rd[i]),
         .ie(ie_v[i]), .expire(expire_v[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        stat_q[i] <= 1'b0;
         else if (expire_v[i])              stat_q[i] <= 1'b1;
         else if (stat_we && bus_wdata[i])  stat_q[i] <= 1'b0;
      end

      // R7: expiry always raises the status bit
      a_r7_status_set: assert property (@(posedge clk) disable iff (!rst_n)
         expire_v[i] |=> stat_q[i]);
      // R8: write-one clears when no expiry coincides
      a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_we && bus_wdata[i] && !expire_v[i]) |=> !stat_q[i]);
   end

   assign irq = stat_q & ie_v;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == STAT_ADDR) bus_rdata = DATA_W'(stat_q);
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr[ADDR_W-1:2] == IDX_W'(i)) begin
            case (bus_addr[1:0])
               2'(OFF_CTL):  bus_rdata = ctl_rd[i];
               2'(OFF_INIT): bus_rdata = DATA_W'(init_rd[i]);
               2'(OFF_CNT):  bus_rdata = DATA_W'(cnt_rd[i]);
               default:      bus_rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: tb/tmr_bank_test.sv
module tmr_bank_test;
   localparam int CLK_PERIOD = 20;
   localparam int NCH  = 3;
   localparam int CW   = 24;
   localparam int AW   = 5;
   localparam int STAT = 4 * NCH;
   localparam int NV   = 5;
   localparam int V_CH  [NV] = '{0, 1, 2, 0, 1};
   localparam int V_MD  [NV] = '{0, 1, 0, 1, 2};
   localparam int V_PRE [NV] = '{0, 2, 3, 1, 0};
   localparam int V_N   [NV] = '{5, 4, 3, 1, 2};
   localparam int V_IE  [NV] = '{1, 1, 0, 0, 1};

   logic clk = 0, rst_n = 0, we = 0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NCH-1:0] irq;
   int checks = 0, errors = 0;

   tmr_bank #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] ctl(int en, int ie, int md, int pre);
      return {1'b0, en[0], ie[0], md[1:0], 19'b0, pre[7:0]};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      addr = AW'(a); wdata = d; we = 1;
      @(negedge clk);
      we = 0;
      #1;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      addr = AW'(a);
      #1;
      d = rdata;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d, c0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1 reset state
      rd(0, d);    check("R1 ctl0", d, 0);
      rd(5, d);    check("R1 init1", d, 0);
      rd(10, d);   check("R1 cnt2", d, 0);
      rd(STAT, d); check("R1 status", d, 0);
      check("R1 irq", 32'(irq), 0);

      for (int v = 0; v < NV; v++) begin
         int b, per, ch;
         ch = V_CH[v]; b = 4 * ch; per = (V_MD[v] == 1);
         wr(b + 1, V_N[v]);
         wr(b, ctl(1, V_IE[v], V_MD[v], V_PRE[v]));
         rd(b + 2, d); check("R5 load on enable", d, V_N[v]);
         repeat ((V_PRE[v] + 1) * V_N[v] - 1) @(negedge clk);
         rd(b + 2, d); check("R2 count before expiry", d, 1);
         rd(STAT, d);  check("R7 no early status", 32'(d[ch]), 0);
         @(negedge clk);
         rd(STAT, d);  check("R7 status at expiry", 32'(d[ch]), 1);
         check("R9 irq gating", 32'(irq[ch]), V_IE[v]);
         rd(b + 2, d); check(per ? "R4 periodic reload" : "R3 oneshot zero",
                             d, per ? V_N[v] : 0);
         rd(b, d);     check(per ? "R4 enable kept" : "R3 enable cleared",
                             d, ctl(per, V_IE[v], V_MD[v], V_PRE[v]));
         wr(b, 0);
         wr(STAT, 0);
         rd(STAT, d);  check("R8 zero write keeps", 32'(d[ch]), 1);
         wr(STAT, 32'(1) << ch);
         rd(STAT, d);  check("R8 w1c clear", d, 0);
         rd(b + 2, c0);
         repeat (8) @(negedge clk);
         rd(b + 2, d); check("R11 stopped count holds", d, c0);
         rd(STAT, d);  check("R11 no expiry when stopped", d, 0);
      end

      // R6 mid-run reload on channel 0, prescale 1
      wr(1, 10);
      wr(0, ctl(1, 1, 0, 1));
      repeat (5) @(negedge clk);
      rd(2, d);    check("R2 count falls every P+1", d, 8);
      wr(1, 4);
      rd(2, d);    check("R6 reload value", d, 4);
      repeat (7) @(negedge clk);
      rd(2, d);    check("R6 restarted phase", d, 1);
      rd(STAT, d); check("R6 no early expiry", d, 0);
      @(negedge clk);
      rd(STAT, d); check("R6 expiry after reload", d, 1);
      check("R9 irq high", 32'(irq), 1);
      wr(STAT, 32'hFFFF_FFFF);
      rd(STAT, d); check("R8 upper bits zero", d, 0);

      // R10 width and zero extension on channel 2, widest prescale
      wr(9, 32'hFFFF_FFFF);
      rd(9, d);    check("R10 init width", d, 32'h00FF_FFFF);
      rd(10, d);   check("R6 disabled write only stores", d, 0);
      wr(8, ctl(1, 0, 3, 255));
      rd(10, d);   check("R10 count zero-extended", d, 32'h00FF_FFFF);
      rd(8, d);    check("R10 control readback", d, 32'h5800_00FF);
      repeat (256) @(negedge clk);
      rd(10, d);   check("R2 prescale 255", d, 32'h00FF_FFFE);
      wr(8, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule